// File: doc/BRIEF.md
# Primary Station Link Controller

This block is the primary side of the link layer in a DNP3 master. It sits between the upper layer, which asks for link operations, and the frame builder and parser that carry bytes to and from the outstation. The upper layer issues four kinds of request: reset the remote link, test it, send confirmed user data, or send unconfirmed user data. The block then emits one control byte per frame to transmit, and the frame builder wraps that byte into a full frame.

The block keeps the alternating frame-count bit. It waits for the outstation's reply and times that wait in ticks of an external timer. When the wait expires it resends the identical byte, up to a configurable number of retries. Each confirmed exchange ends with exactly one completion pulse: success or failure. A separate flag marks a reply that said the outstation's receive buffer is full.

There are two idle states. The unlinked idle state holds after reset and after any failure. The linked idle state holds after a successful link reset. A test or confirmed-data request made while unlinked first performs a link reset, then sends the requested frame.

Top module: `linkPrimaryTop`

## Requirements
- R1: After reset, no frame is sent and no report pulse is raised, and the controller is unlinked.
- R2: Every transmitted control byte has bit 7 = 1 and bit 6 = 1. Bits 3..0 hold the function: 0 = link reset, 2 = link test, 3 = confirmed data, 4 = unconfirmed data. Bit 4 (count valid) is 1 only for functions 2 and 3. Bit 5 carries the frame-count bit when bit 4 is 1 and is 0 otherwise.
- R3: A received byte is treated as a reply only when bits 7, 6 and 5 are all 0. Function 0 is an acknowledge and function 1 is a negative acknowledge. Bit 4 is the outstation-full flag. Any other byte has no effect.
- R4: A reset request sends function 0 and waits. An acknowledge gives a success pulse, enters the linked idle state and sets the frame-count bit to 1.
- R5: A test or confirmed-data request made while unlinked sends a link reset first. An acknowledge that is not full then sends the requested frame with frame-count bit 1.
- R6: An unconfirmed-data request sends function 4 from either idle state, with no wait and no report pulse.
- R7: An acknowledge to a test or confirmed-data frame gives a success pulse and inverts the frame-count bit. The next counted frame therefore carries the opposite value.
- R8: If no reply arrives within `timeoutTicks` timer ticks, the last byte is resent unchanged. After `maxRetries` resends, the next expiry gives a failure pulse and the controller becomes unlinked.
- R9: A negative acknowledge in any wait state gives a failure pulse and the controller becomes unlinked.
- R10: An acknowledge with the full flag raises `remoteBusy` together with its completion pulse. During a reset made on behalf of a pending request, that acknowledge suppresses the pending frame and gives a failure pulse, and the controller stays linked.
- R11: Requests made while waiting are ignored. When several requests arrive in one cycle, the priority is reset, then test, then confirmed data, then unconfirmed data.
- R12: All outputs are registered and appear one cycle after the triggering edge. A completion pulse never coincides with a transmit, and success never coincides with failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqReset | input | 1 | Upper-layer request: reset remote link |
| reqTest | input | 1 | Upper-layer request: test link |
| reqConfData | input | 1 | Upper-layer request: confirmed user data |
| reqUnconfData | input | 1 | Upper-layer request: unconfirmed user data |
| rxValid | input | 1 | Received control byte strobe |
| rxCtrl | input | 8 | Received control byte |
| tick | input | 1 | Timer tick for response timeout |
| timeoutTicks | input | TICK_W | Ticks to wait for a reply (at least 1) |
| maxRetries | input | RETRY_W | Resends allowed before failure |
| txValid | output | 1 | Transmit strobe, one cycle |
| txCtrl | output | 8 | Control byte to transmit |
| doneOk | output | 1 | Confirmed exchange succeeded |
| doneFail | output | 1 | Confirmed exchange failed |
| remoteBusy | output | 1 | Outstation buffer reported full |

## Verification
The assertions check, on every cycle, the shape of each transmitted byte: the fixed top bits, count valid set only for the counted functions, and a zero count bit when count valid is clear. They also check that completion pulses are exclusive with each other and with transmits, that the full flag appears only with a completion, and that a byte with the primary flag set changes nothing.

Only the bench scenarios can show the behaviour that depends on history. That covers the frame-count sequence across successive exchanges, a link reset inserted ahead of a request made while unlinked, the exact tick on which a resend or a failure happens, and the return to the unlinked state after a failure.

// File: rtl/linkPrimaryPkg.sv
`timescale 1ns/1ps
package linkPrimaryPkg;

  typedef enum logic [2:0] {
    ST_IDLE_COLD,
    ST_IDLE_LINKED,
    ST_RST_WAIT,
    ST_RST_PEND,
    ST_TEST_WAIT,
    ST_DATA_WAIT
  } linkState_t;

  localparam logic [3:0] FN_RESET  = 4'd0;
  localparam logic [3:0] FN_TEST   = 4'd2;
  localparam logic [3:0] FN_CONF   = 4'd3;
  localparam logic [3:0] FN_UNCONF = 4'd4;
  localparam logic [3:0] FN_ACK    = 4'd0;
  localparam logic [3:0] FN_NACK   = 4'd1;

  // strobes from control to datapath
  typedef struct packed {
    logic       sendNew;
    logic       resend;
    logic [3:0] func;
    logic       countValid;
    logic       fcbSet;
    logic       fcbToggle;
    logic       waiting;
    logic       reportOk;
    logic       reportFail;
    logic       reportBusy;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic ack;
    logic nack;
    logic busy;
    logic timeout;
    logic canRetry;
  } dpStatus_t;

endpackage

// File: rtl/linkPrimaryData.sv
`timescale 1ns/1ps
module linkPrimaryData
  import linkPrimaryPkg::*;
#(
  parameter int TICK_W  = 8,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic               tick,
  input  logic [TICK_W-1:0]  timeoutTicks,
  input  logic [RETRY_W-1:0] maxRetries,
  input  logic               rxValid,
  input  logic [7:0]         rxCtrl,
  output dpStatus_t          stat,
  output logic               txValid,
  output logic [7:0]         txCtrl,
  output logic               doneOk,
  output logic               doneFail,
  output logic               remoteBusy
);

  localparam logic [TICK_W:0] TICK_ONE = {{TICK_W{1'b0}}, 1'b1};

  logic               fcbQ;
  logic [7:0]         lastCtrl;
  logic [TICK_W-1:0]  tickCnt;
  logic [RETRY_W-1:0] retryCnt;
  logic               frameFcb;
  logic [7:0]         newCtrl;
  logic               rxReply;
  logic [TICK_W:0]    tickNext;

  always_comb begin
    frameFcb = ctl.countValid & (ctl.fcbSet | fcbQ);
    newCtrl  = {1'b1, 1'b1, frameFcb, ctl.countValid, ctl.func};
    rxReply  = rxValid & ~rxCtrl[7] & ~rxCtrl[6] & ~rxCtrl[5];
    tickNext = {1'b0, tickCnt} + TICK_ONE;

    stat.ack      = rxReply & (rxCtrl[3:0] == FN_ACK);
    stat.nack     = rxReply & (rxCtrl[3:0] == FN_NACK);
    stat.busy     = rxCtrl[4];
    stat.timeout  = ctl.waiting & tick & (tickNext >= {1'b0, timeoutTicks});
    stat.canRetry = retryCnt < maxRetries;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fcbQ       <= 1'b0;
      lastCtrl   <= '0;
      tickCnt    <= '0;
      retryCnt   <= '0;
      txValid    <= 1'b0;
      txCtrl     <= '0;
      doneOk     <= 1'b0;
      doneFail   <= 1'b0;
      remoteBusy <= 1'b0;
    end else begin
      txValid    <= ctl.sendNew | ctl.resend;
      doneOk     <= ctl.reportOk;
      doneFail   <= ctl.reportFail;
      remoteBusy <= ctl.reportBusy;

      if (ctl.resend) begin
        txCtrl <= lastCtrl;
      end else if (ctl.sendNew) begin
        txCtrl   <= newCtrl;
        lastCtrl <= newCtrl;
      end

      if (ctl.fcbSet) begin
        fcbQ <= 1'b1;
      end else if (ctl.fcbToggle) begin
        fcbQ <= ~fcbQ;
      end

      if (ctl.sendNew | ctl.resend) begin
        tickCnt <= '0;
      end else if (ctl.waiting & tick) begin
        tickCnt <= tickNext[TICK_W-1:0];
      end

      if (ctl.sendNew) begin
        retryCnt <= '0;
      end else if (ctl.resend) begin
        retryCnt <= retryCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/linkPrimaryCtrl.sv
`timescale 1ns/1ps
module linkPrimaryCtrl
  import linkPrimaryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqReset,
  input  logic       reqTest,
  input  logic       reqConfData,
  input  logic       reqUnconfData,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl
);

  linkState_t state, stateNext;
  logic       pendData, pendDataNext;

  always_comb begin
    ctl          = '0;
    stateNext    = state;
    pendDataNext = pendData;

    case (state)
      ST_IDLE_COLD, ST_IDLE_LINKED: begin
        if (reqReset) begin
          ctl.sendNew = 1'b1;
          ctl.func    = FN_RESET;
          stateNext   = ST_RST_WAIT;
        end else if (reqTest | reqConfData) begin
          ctl.sendNew = 1'b1;
          if (state == ST_IDLE_LINKED) begin
            ctl.func       = reqTest ? FN_TEST : FN_CONF;
            ctl.countValid = 1'b1;
            stateNext      = reqTest ? ST_TEST_WAIT : ST_DATA_WAIT;
          end else begin
            ctl.func     = FN_RESET;
            pendDataNext = ~reqTest;
            stateNext    = ST_RST_PEND;
          end
        end else if (reqUnconfData) begin
          ctl.sendNew = 1'b1;
          ctl.func    = FN_UNCONF;
        end
      end

      ST_RST_WAIT, ST_RST_PEND, ST_TEST_WAIT, ST_DATA_WAIT: begin
        ctl.waiting = 1'b1;
        if (stat.ack) begin
          if (state == ST_RST_WAIT) begin
            ctl.fcbSet     = 1'b1;
            ctl.reportOk   = 1'b1;
            ctl.reportBusy = stat.busy;
            stateNext      = ST_IDLE_LINKED;
          end else if (state == ST_RST_PEND) begin
            ctl.fcbSet = 1'b1;
            if (stat.busy) begin
              ctl.reportFail = 1'b1;
              ctl.reportBusy = 1'b1;
              stateNext      = ST_IDLE_LINKED;
            end else begin
              ctl.sendNew    = 1'b1;
              ctl.countValid = 1'b1;
              ctl.func       = pendData ? FN_CONF : FN_TEST;
              stateNext      = pendData ? ST_DATA_WAIT : ST_TEST_WAIT;
            end
          end else begin
            ctl.fcbToggle  = 1'b1;
            ctl.reportOk   = 1'b1;
            ctl.reportBusy = stat.busy;
            stateNext      = ST_IDLE_LINKED;
          end
        end else if (stat.nack) begin
          ctl.reportFail = 1'b1;
          stateNext      = ST_IDLE_COLD;
        end else if (stat.timeout) begin
          if (stat.canRetry) begin
            ctl.resend = 1'b1;
          end else begin
            ctl.reportFail = 1'b1;
            stateNext      = ST_IDLE_COLD;
          end
        end
      end

      default: stateNext = ST_IDLE_COLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE_COLD;
      pendData <= 1'b0;
    end else begin
      state    <= stateNext;
      pendData <= pendDataNext;
    end
  end

endmodule

// File: rtl/linkPrimaryTop.sv
`timescale 1ns/1ps
module linkPrimaryTop
  import linkPrimaryPkg::*;
#(
  parameter int TICK_W  = 8,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqReset,
  input  logic               reqTest,
  input  logic               reqConfData,
  input  logic               reqUnconfData,
  input  logic               rxValid,
  input  logic [7:0]         rxCtrl,
  input  logic               tick,
  input  logic [TICK_W-1:0]  timeoutTicks,
  input  logic [RETRY_W-1:0] maxRetries,
  output logic               txValid,
  output logic [7:0]         txCtrl,
  output logic               doneOk,
  output logic               doneFail,
  output logic               remoteBusy
);

  ctlStrobe_t ctl;
  dpStatus_t  stat;

  linkPrimaryCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqReset     (reqReset),
    .reqTest      (reqTest),
    .reqConfData  (reqConfData),
    .reqUnconfData(reqUnconfData),
    .stat         (stat),
    .ctl          (ctl)
  );

  linkPrimaryData #(.TICK_W(TICK_W), .RETRY_W(RETRY_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .tick        (tick),
    .timeoutTicks(timeoutTicks),
    .maxRetries  (maxRetries),
    .rxValid     (rxValid),
    .rxCtrl      (rxCtrl),
    .stat        (stat),
    .txValid     (txValid),
    .txCtrl      (txCtrl),
    .doneOk      (doneOk),
    .doneFail    (doneFail),
    .remoteBusy  (remoteBusy)
  );

endmodule

// File: rtl/linkPrimaryChk.sv
`timescale 1ns/1ps
module linkPrimaryChk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReset,
  input logic       reqTest,
  input logic       reqConfData,
  input logic       reqUnconfData,
  input logic       rxValid,
  input logic [7:0] rxCtrl,
  input logic       tick,
  input logic       txValid,
  input logic [7:0] txCtrl,
  input logic       doneOk,
  input logic       doneFail,
  input logic       remoteBusy
);

  logic anyReq;
  assign anyReq = reqReset | reqTest | reqConfData | reqUnconfData;

  // R2
  tx_origin_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txCtrl[7:6] == 2'b11));

  // R2
  count_valid_func_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txCtrl[4] == ((txCtrl[3:0] == 4'd2) || (txCtrl[3:0] == 4'd3))));

  // R2
  uncounted_bit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txCtrl[4]) |-> !txCtrl[5]);

  // R12
  report_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && doneFail) && !(txValid && (doneOk || doneFail)));

  // R10
  busy_with_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    remoteBusy |-> (doneOk || doneFail));

  // R3
  primary_rx_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxCtrl[6] && !tick && !anyReq) |=> (!txValid && !doneOk && !doneFail));

endmodule

bind linkPrimaryTop linkPrimaryChk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .reqReset     (reqReset),
  .reqTest      (reqTest),
  .reqConfData  (reqConfData),
  .reqUnconfData(reqUnconfData),
  .rxValid      (rxValid),
  .rxCtrl       (rxCtrl),
  .tick         (tick),
  .txValid      (txValid),
  .txCtrl       (txCtrl),
  .doneOk       (doneOk),
  .doneFail     (doneFail),
  .remoteBusy   (remoteBusy)
);

// File: tb/linkPrimaryTop_test.sv
`timescale 1ns/1ps
module linkPrimaryTop_test;

  localparam int TICK_W  = 8;
  localparam int RETRY_W = 3;
  localparam int TMO     = 3;
  localparam int RETRIES = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqReset = 1'b0, reqTest = 1'b0, reqConfData = 1'b0, reqUnconfData = 1'b0;
  logic               rxValid = 1'b0;
  logic [7:0]         rxCtrl = '0;
  logic               tick = 1'b0;
  logic [TICK_W-1:0]  timeoutTicks = TMO[TICK_W-1:0];
  logic [RETRY_W-1:0] maxRetries = RETRIES[RETRY_W-1:0];
  logic               txValid, doneOk, doneFail, remoteBusy;
  logic [7:0]         txCtrl;

  int  nChecks = 0;
  int  nFail = 0;
  bit  linked;
  bit  fcb;

  always #10 clk = ~clk;

  linkPrimaryTop #(.TICK_W(TICK_W), .RETRY_W(RETRY_W)) uut (
    .clk(clk), .rstN(rstN),
    .reqReset(reqReset), .reqTest(reqTest), .reqConfData(reqConfData), .reqUnconfData(reqUnconfData),
    .rxValid(rxValid), .rxCtrl(rxCtrl), .tick(tick),
    .timeoutTicks(timeoutTicks), .maxRetries(maxRetries),
    .txValid(txValid), .txCtrl(txCtrl), .doneOk(doneOk), .doneFail(doneFail), .remoteBusy(remoteBusy)
  );

  function automatic logic [7:0] mk(input bit f, input bit cv, input logic [3:0] fn);
    return {2'b11, f & cv, cv, fn};
  endfunction

  function automatic logic [7:0] sec(input logic [3:0] fn, input bit full);
    return {3'b000, full, fn};
  endfunction

  function automatic logic [11:0] expOut(input bit tv, input logic [7:0] c, input bit ok, input bit fl, input bit bz);
    return {tv, tv ? c : 8'h00, ok, fl, bz};
  endfunction

  function automatic logic [11:0] obs();
    return {txValid, txValid ? txCtrl : 8'h00, doneOk, doneFail, remoteBusy};
  endfunction

  task automatic chk(input string tag, input logic [11:0] exp);
    logic [11:0] act;
    act = obs();
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h (tx,ctrl,ok,fail,busy)", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // kind: 0 reset, 1 test, 2 confirmed, 3 unconfirmed
  task automatic req(input int kind);
    reqReset = (kind == 0); reqTest = (kind == 1);
    reqConfData = (kind == 2); reqUnconfData = (kind == 3);
    cyc();
    reqReset = 0; reqTest = 0; reqConfData = 0; reqUnconfData = 0;
  endtask

  task automatic rx(input logic [7:0] c);
    rxValid = 1'b1; rxCtrl = c;
    cyc();
    rxValid = 1'b0;
  endtask

  task automatic tickN(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
      tick = 1'b0;
      if (i < n - 1) chk(tag, expOut(0, 0, 0, 0, 0));
    end
  endtask

  task automatic waitResp(input logic [7:0] sent, input bit isReset);
    int nTo;
    int r;
    nTo = $urandom_range(0, RETRIES + 1);
    for (int i = 0; i < nTo; i++) begin
      tickN(TMO, "R8 quiet before expiry");
      if (i < RETRIES) begin
        chk("R8 resend same byte", expOut(1, sent, 0, 0, 0));
      end else begin
        chk("R8 retries exhausted", expOut(0, 0, 0, 1, 0));
        linked = 0;
        return;
      end
    end
    r = $urandom_range(0, 3);
    if (r == 0) begin
      rx(sec(4'd1, 1'b0));
      chk("R9 nack fails", expOut(0, 0, 0, 1, 0));
      linked = 0;
    end else begin
      rx(sec(4'd0, r == 3));
      chk("R7 ack completes", expOut(0, 0, 1, 0, r == 3));
      if (isReset) begin fcb = 1; linked = 1; end
      else fcb = ~fcb;
    end
  endtask

  task automatic randomOp();
    int op;
    logic [7:0] sent;
    logic [3:0] fn;
    op = $urandom_range(0, 3);
    req(op);
    if (op == 3) begin
      chk("R6 unconfirmed sent", expOut(1, mk(0, 0, 4'd4), 0, 0, 0));
    end else if (op == 0) begin
      sent = mk(0, 0, 4'd0);
      chk("R4 reset frame", expOut(1, sent, 0, 0, 0));
      waitResp(sent, 1);
    end else begin
      fn = (op == 1) ? 4'd2 : 4'd3;
      if (!linked) begin
        chk("R5 reset first", expOut(1, mk(0, 0, 4'd0), 0, 0, 0));
        rx(sec(4'd0, 1'b0));
        fcb = 1; linked = 1;
        sent = mk(1, 1, fn);
        chk("R5 pending frame", expOut(1, sent, 0, 0, 0));
      end else begin
        sent = mk(fcb, 1, fn);
        chk("R7 counted frame", expOut(1, sent, 0, 0, 0));
      end
      waitResp(sent, 0);
    end
    cyc();
    chk("R12 quiet after op", expOut(0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd24680);
    repeat (3) cyc();
    chk("R1 during reset", expOut(0, 0, 0, 0, 0));
    rstN = 1'b1;
    cyc();
    chk("R1 after reset", expOut(0, 0, 0, 0, 0));

    // confirmed data while unlinked: reset first (R5)
    req(2);
    chk("R5 reset inserted", expOut(1, mk(0, 0, 4'd0), 0, 0, 0));
    rx(sec(4'd0, 1'b0));
    chk("R5 data with count bit 1", expOut(1, mk(1, 1, 4'd3), 0, 0, 0));
    rx(sec(4'd0, 1'b0));
    chk("R7 data ack", expOut(0, 0, 1, 0, 0));

    // next counted frame carries toggled bit (R7)
    req(2);
    chk("R7 toggled count bit", expOut(1, mk(0, 1, 4'd3), 0, 0, 0));
    rx(sec(4'd0, 1'b0));
    chk("R7 second ack", expOut(0, 0, 1, 0, 0));

    // test link, requests ignored while waiting, timeouts (R8, R11)
    req(1);
    chk("R2 test frame", expOut(1, mk(1, 1, 4'd2), 0, 0, 0));
    req(0);
    chk("R11 request ignored in wait", expOut(0, 0, 0, 0, 0));
    tickN(TMO, "R8 quiet");
    chk("R8 first resend", expOut(1, mk(1, 1, 4'd2), 0, 0, 0));
    tickN(TMO, "R8 quiet");
    chk("R8 second resend", expOut(1, mk(1, 1, 4'd2), 0, 0, 0));
    tickN(TMO, "R8 quiet");
    chk("R8 exhausted fail", expOut(0, 0, 0, 1, 0));

    // unlinked again; non-reply bytes ignored (R3)
    req(2);
    chk("R8 unlinked after fail", expOut(1, mk(0, 0, 4'd0), 0, 0, 0));
    rx(8'h40);
    chk("R3 primary-flag byte ignored", expOut(0, 0, 0, 0, 0));
    rx(8'h0B);
    chk("R3 link status ignored", expOut(0, 0, 0, 0, 0));
    rx(8'h20);
    chk("R3 reserved bit byte ignored", expOut(0, 0, 0, 0, 0));
    rx(sec(4'd0, 1'b1));
    chk("R10 full suppresses pending", expOut(0, 0, 0, 1, 1));

    // linked with count bit 1 (R10), then negative acknowledge (R9)
    req(2);
    chk("R10 linked after full ack", expOut(1, mk(1, 1, 4'd3), 0, 0, 0));
    rx(sec(4'd1, 1'b0));
    chk("R9 nack fails", expOut(0, 0, 0, 1, 0));

    // unconfirmed from unlinked idle (R6)
    req(3);
    chk("R6 unconfirmed cold", expOut(1, mk(0, 0, 4'd4), 0, 0, 0));
    cyc();
    chk("R6 no report", expOut(0, 0, 0, 0, 0));

    // explicit reset with full flag (R4, R10)
    req(0);
    chk("R4 reset frame", expOut(1, mk(0, 0, 4'd0), 0, 0, 0));
    rx(sec(4'd0, 1'b1));
    chk("R4 reset ack with busy", expOut(0, 0, 1, 0, 1));
    req(3);
    chk("R6 unconfirmed linked", expOut(1, mk(0, 0, 4'd4), 0, 0, 0));

    // priority among simultaneous requests (R11)
    reqTest = 1; reqConfData = 1; reqUnconfData = 1;
    cyc();
    reqTest = 0; reqConfData = 0; reqUnconfData = 0;
    chk("R11 test wins", expOut(1, mk(1, 1, 4'd2), 0, 0, 0));
    rx(sec(4'd0, 1'b0));
    chk("R7 test ack", expOut(0, 0, 1, 0, 0));

    linked = 1; fcb = 0;
    for (int n = 0; n < 60; n++) randomOp();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule